// File: doc/BRIEF.md
# Serial Byte-Memory Slave Engine

This block is the slave side of a four-wire serial memory port in SPI modes 0 and 3. It receives chip select, serial clock, serial data-in and an active-low pause input from an external master. It decodes one command byte per select frame and performs the matching action: it sets or clears a write-enable latch, returns a status byte, forwards a status-write request, or streams data to or from an internal array of 8192 bytes. The array is held as 2048 words of 32 bits.

The serial pins are not used as clocks. A fast system clock oversamples them through synchronizer chains, and every action happens on a detected edge. Bytes travel most significant bit first. There is no busy period: each received data byte becomes a one-cycle write request as soon as its eighth bit arrives, and the address counter then advances, wrapping from the top of the array to zero. Whether a byte may be stored is decided by an external protection unit. That unit returns a permit for the address shown on `wr_addr`, and the engine stores the byte only if the permit is high and the write-enable latch is set.

The pause input freezes the engine's view of the serial clock and chip select, and releases the data-out enable. The transfer then continues from the bit where it stopped.

Top module: `serial_mem_slave`

## Requirements
- R1: After reset `spi_miso_oe`, `wr_req`, `stat_wr_req` and `wel` are all low.
- R2: Input bits are taken on rising serial-clock edges and output bits change after falling edges, both most significant bit first. Both clock idle levels work: low in mode 0, high in mode 3.
- R3: Command 0x06 sets `wel` and command 0x04 clears it. Both take effect as the command's eighth bit is received.
- R4: Command 0x05 returns the status byte {prot_cfg[2], 0, 0, 0, prot_cfg[1], prot_cfg[0], wel, 0}, and repeats it while clocks continue.
- R5: Command 0x01 takes one byte. It raises `stat_wr_req` for one cycle with that byte on `stat_wr_data`, but only if `wel` and `stat_permit` are both high. It clears `wel` when select rises.
- R6: Command 0x03 takes two address bytes, of which the top three bits are ignored. It then returns array bytes from that address onward, and data-in is ignored while those bytes are returned.
- R7: Command 0x02 takes two address bytes and then data bytes. Each byte is stored once its eighth bit is in, but only if `wel` is set and `wr_permit` is high for that address. `wel` clears when select rises.
- R8: The address advances after every data byte, and 0x1FFF is followed by 0x0000.
- R9: Only the first byte of a select frame is decoded as a command. Bytes after a command that takes no data are ignored, and a rising select ends the frame.
- R10: A first byte that is not one of the six commands makes the rest of the frame ignored, with no output driven and nothing stored.
- R11: A pause that begins while the serial clock is low disables the output and blocks clock and select edges until it is released. The transfer then resumes with the same bit.
- R12: `spi_miso_oe` is high only while read data or status data is being shifted out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the serial clock |
| rst_n | input | 1 | Synchronous active-low reset |
| spi_sclk | input | 1 | Serial clock from master |
| spi_csn | input | 1 | Active-low chip select |
| spi_mosi | input | 1 | Serial data in |
| spi_holdn | input | 1 | Active-low pause |
| spi_miso | output | 1 | Serial data out |
| spi_miso_oe | output | 1 | Output enable for the data-out pad |
| prot_cfg | input | 3 | Protection configuration bits reported in the status byte |
| stat_permit | input | 1 | Protection unit allows a status write |
| stat_wr_req | output | 1 | One-cycle status write request |
| stat_wr_data | output | 8 | Byte for the status write |
| wel | output | 1 | Write-enable latch |
| wr_req | output | 1 | One-cycle array write request |
| wr_addr | output | 13 | Address of the requested write |
| wr_data | output | 8 | Data of the requested write |
| wr_permit | input | 1 | Protection unit allows writing `wr_addr` |

## Verification
The bench drives bursts that run across the array top. A counter that saturated, or dropped into the ignored top address bits, would return wrong bytes after 0x1FFF. It sends a command byte followed by more bytes in the same frame, and sends an unknown command followed by bytes that look like a write. A decoder that re-armed after the first byte would then store data or drive the output. It pauses a read in the middle of a byte while the serial clock keeps toggling: a design that counted those edges would return shifted data, and one that kept driving would show the enable high. It also writes across a permit boundary, and writes or status-writes with the latch clear. A gate that ignored either condition would change bytes or raise a request that must not appear.

// File: rtl/serial_mem_pkg.sv
// Package: command encodings and controller state type shared by the
// serial memory slave engine and its checker.
package serial_mem_pkg;

    localparam logic [7:0] CMD_WEN_SET = 8'h06;
    localparam logic [7:0] CMD_WEN_CLR = 8'h04;
    localparam logic [7:0] CMD_STAT_RD = 8'h05;
    localparam logic [7:0] CMD_STAT_WR = 8'h01;
    localparam logic [7:0] CMD_MEM_RD  = 8'h03;
    localparam logic [7:0] CMD_MEM_WR  = 8'h02;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_CMD,
        ST_ADDR_HI,
        ST_ADDR_LO,
        ST_RD_DATA,
        ST_WR_DATA,
        ST_STAT_OUT,
        ST_STAT_IN,
        ST_DISCARD
    } ctl_state_t;

endpackage

// File: rtl/serial_mem_front.sv
// Module: serial_mem_front
// Purpose: synchronizes the four serial pins into the system clock domain
// and produces edge pulses for the serial clock and chip select.
// The pause input is taken only while the synchronized serial clock is low.
// While paused, the held copies of clock and select are frozen, so no edge
// pulses appear.
// Assumes: the serial clock half period spans at least SYNC_STAGES+3 cycles.
module serial_mem_front #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk,
    input  logic csn,
    input  logic mosi,
    input  logic holdn,
    output logic sclk_rise,
    output logic sclk_fall,
    output logic sel_fall,
    output logic sel_rise,
    output logic sel_active,
    output logic mosi_bit,
    output logic paused
);
    localparam int NSIG = 4;
    // Pin order in the vector: {holdn, mosi, csn, sclk}, idle values below
    localparam logic [NSIG-1:0] IDLE_VAL = 4'b1010;

    logic [NSIG-1:0] raw;
    logic [NSIG-1:0] synced;
    logic            sclk_q;
    logic            csn_q;
    logic            hold_q;

    assign raw = {holdn, mosi, csn, sclk};

    for (genvar g = 0; g < NSIG; g++) begin : g_sync
        logic [SYNC_STAGES-1:0] chain;
        // Shift each pin through its synchronizer chain
        always_ff @(posedge clk) begin
            if (!rst_n) chain <= {SYNC_STAGES{IDLE_VAL[g]}};
            else        chain <= {chain[SYNC_STAGES-2:0], raw[g]};
        end
        assign synced[g] = chain[SYNC_STAGES-1];
    end

    // Take the pause while the clock is low; freeze clock/select copies while paused
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q <= 1'b0;
            sclk_q <= 1'b0;
            csn_q  <= 1'b1;
        end else begin
            if (!synced[0]) hold_q <= ~synced[3];
            if (!hold_q) begin
                sclk_q <= synced[0];
                csn_q  <= synced[1];
            end
        end
    end

    assign sclk_rise  = ~hold_q &  synced[0] & ~sclk_q;
    assign sclk_fall  = ~hold_q & ~synced[0] &  sclk_q;
    assign sel_fall   = ~hold_q & ~synced[1] &  csn_q;
    assign sel_rise   = ~hold_q &  synced[1] & ~csn_q;
    assign sel_active = ~csn_q;
    assign mosi_bit   = synced[2];
    assign paused     = hold_q;

endmodule

// File: rtl/serial_mem_array.sv
// Module: serial_mem_array
// Purpose: byte-addressed storage held as 32-bit words with byte-lane writes.
// Reads are combinational from the byte address. The contents have no reset:
// the array models memory, not control state.
module serial_mem_array #(
    parameter int ADDR_W = 13
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [7:0]        wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [7:0]        rdata
);
    localparam int LANE_BITS = 2;
    localparam int WORDS     = 2 ** (ADDR_W - LANE_BITS);

    logic [31:0] mem [WORDS];

    // Store one byte lane of the addressed word
    always_ff @(posedge clk) begin
        if (we) mem[waddr[ADDR_W-1:LANE_BITS]][waddr[LANE_BITS-1:0]*8 +: 8] <= wdata;
    end

    // Select the addressed byte lane for reading
    always_comb begin
        rdata = mem[raddr[ADDR_W-1:LANE_BITS]][raddr[LANE_BITS-1:0]*8 +: 8];
    end

endmodule

// File: rtl/serial_mem_ctrl.sv
// Module: serial_mem_ctrl
// Purpose: counts bits, decodes the command byte, captures the address,
// runs the address counter, issues write and status-write requests and
// shifts read or status data out.
// Assumes: edge pulses come from serial_mem_front, and a select edge never
// arrives in the same cycle as a clock edge.
module serial_mem_ctrl
    import serial_mem_pkg::*;
#(
    parameter int ADDR_W = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_rise,
    input  logic              sclk_fall,
    input  logic              sel_fall,
    input  logic              sel_rise,
    input  logic              sel_active,
    input  logic              mosi_bit,
    input  logic [7:0]        rd_byte,
    input  logic [2:0]        prot_cfg,
    input  logic              stat_permit,
    output logic [ADDR_W-1:0] addr_cnt,
    output logic              wr_req,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [7:0]        wr_data,
    output logic              stat_wr_req,
    output logic [7:0]        stat_wr_data,
    output logic              wel,
    output logic              miso,
    output logic              drive,
    output ctl_state_t        state,
    output logic [2:0]        bit_cnt
);
    localparam int HI_W = ADDR_W - 8;

    logic [6:0] in_sh;
    logic [7:0] out_sh;
    logic [7:0] byte_in;
    logic [7:0] stat_byte;
    logic       op_is_wr;
    logic       wel_drop;

    assign byte_in   = {in_sh, mosi_bit};
    assign stat_byte = {prot_cfg[2], 3'b000, prot_cfg[1:0], wel, 1'b0};
    assign miso      = out_sh[7];

    // Frame sequencing, byte decode, address counting and output shifting
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state        <= ST_IDLE;
            bit_cnt      <= 3'd0;
            in_sh        <= 7'd0;
            out_sh       <= 8'd0;
            addr_cnt     <= '0;
            op_is_wr     <= 1'b0;
            wel_drop     <= 1'b0;
            wel          <= 1'b0;
            drive        <= 1'b0;
            wr_req       <= 1'b0;
            wr_addr      <= '0;
            wr_data      <= 8'd0;
            stat_wr_req  <= 1'b0;
            stat_wr_data <= 8'd0;
        end else begin
            wr_req      <= 1'b0;
            stat_wr_req <= 1'b0;
            if (sel_fall) begin
                state    <= ST_CMD;
                bit_cnt  <= 3'd0;
                drive    <= 1'b0;
                wel_drop <= 1'b0;
            end else if (sel_rise) begin
                state <= ST_IDLE;
                drive <= 1'b0;
                if (wel_drop) wel <= 1'b0;
            end else if (state != ST_IDLE && sel_active) begin
                if (sclk_rise) begin
                    bit_cnt <= bit_cnt + 3'd1;
                    in_sh   <= byte_in[6:0];
                    if (bit_cnt == 3'd7) begin
                        case (state)
                            ST_CMD: begin
                                case (byte_in)
                                    CMD_WEN_SET: begin wel <= 1'b1; state <= ST_DISCARD; end
                                    CMD_WEN_CLR: begin wel <= 1'b0; state <= ST_DISCARD; end
                                    CMD_STAT_RD: state <= ST_STAT_OUT;
                                    CMD_STAT_WR: begin wel_drop <= 1'b1; state <= ST_STAT_IN; end
                                    CMD_MEM_RD:  begin op_is_wr <= 1'b0; state <= ST_ADDR_HI; end
                                    CMD_MEM_WR:  begin
                                        op_is_wr <= 1'b1;
                                        wel_drop <= 1'b1;
                                        state    <= ST_ADDR_HI;
                                    end
                                    default:     state <= ST_DISCARD;
                                endcase
                            end
                            ST_ADDR_HI: begin
                                addr_cnt[ADDR_W-1:8] <= byte_in[HI_W-1:0];
                                state                <= ST_ADDR_LO;
                            end
                            ST_ADDR_LO: begin
                                addr_cnt[7:0] <= byte_in;
                                state         <= op_is_wr ? ST_WR_DATA : ST_RD_DATA;
                            end
                            ST_WR_DATA: begin
                                wr_req   <= 1'b1;
                                wr_addr  <= addr_cnt;
                                wr_data  <= byte_in;
                                addr_cnt <= addr_cnt + ADDR_W'(1);
                            end
                            ST_RD_DATA: addr_cnt <= addr_cnt + ADDR_W'(1);
                            ST_STAT_IN: begin
                                stat_wr_req  <= wel & stat_permit;
                                stat_wr_data <= byte_in;
                                state        <= ST_DISCARD;
                            end
                            default: ;
                        endcase
                    end
                end
                if (sclk_fall && (state == ST_RD_DATA || state == ST_STAT_OUT)) begin
                    drive <= 1'b1;
                    if (bit_cnt == 3'd0) out_sh <= (state == ST_RD_DATA) ? rd_byte : stat_byte;
                    else                 out_sh <= {out_sh[6:0], 1'b0};
                end
            end
        end
    end

endmodule

// File: rtl/serial_mem_slave.sv
// Module: serial_mem_slave (top)
// Purpose: joins the pin front end, the command controller and the byte
// array. A requested write is stored only when the write-enable latch
// and the external permit are both high.
// Assumes: wr_permit is a combinational function of wr_addr in the
// protection unit, valid in the cycle wr_req is high.
module serial_mem_slave
    import serial_mem_pkg::*;
#(
    parameter int ADDR_W      = 13,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              spi_sclk,
    input  logic              spi_csn,
    input  logic              spi_mosi,
    input  logic              spi_holdn,
    output logic              spi_miso,
    output logic              spi_miso_oe,
    input  logic [2:0]        prot_cfg,
    input  logic              stat_permit,
    output logic              stat_wr_req,
    output logic [7:0]        stat_wr_data,
    output logic              wel,
    output logic              wr_req,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [7:0]        wr_data,
    input  logic              wr_permit
);
    logic              sclk_rise, sclk_fall, sel_fall, sel_rise, sel_active;
    logic              mosi_bit, paused, drive, mem_we;
    logic [ADDR_W-1:0] addr_cnt;
    logic [7:0]        rd_byte;
    ctl_state_t        ctl_state;
    logic [2:0]        bit_cnt;

    serial_mem_front #(.SYNC_STAGES(SYNC_STAGES)) front_i (
        .clk(clk), .rst_n(rst_n),
        .sclk(spi_sclk), .csn(spi_csn), .mosi(spi_mosi), .holdn(spi_holdn),
        .sclk_rise(sclk_rise), .sclk_fall(sclk_fall),
        .sel_fall(sel_fall), .sel_rise(sel_rise), .sel_active(sel_active),
        .mosi_bit(mosi_bit), .paused(paused)
    );

    serial_mem_ctrl #(.ADDR_W(ADDR_W)) ctrl_i (
        .clk(clk), .rst_n(rst_n),
        .sclk_rise(sclk_rise), .sclk_fall(sclk_fall),
        .sel_fall(sel_fall), .sel_rise(sel_rise), .sel_active(sel_active),
        .mosi_bit(mosi_bit), .rd_byte(rd_byte),
        .prot_cfg(prot_cfg), .stat_permit(stat_permit),
        .addr_cnt(addr_cnt),
        .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data),
        .stat_wr_req(stat_wr_req), .stat_wr_data(stat_wr_data),
        .wel(wel), .miso(spi_miso), .drive(drive),
        .state(ctl_state), .bit_cnt(bit_cnt)
    );

    serial_mem_array #(.ADDR_W(ADDR_W)) array_i (
        .clk(clk), .we(mem_we), .waddr(wr_addr), .wdata(wr_data),
        .raddr(addr_cnt), .rdata(rd_byte)
    );

    assign mem_we      = wr_req & wr_permit & wel;
    assign spi_miso_oe = drive & sel_active & ~paused;

endmodule

// File: rtl/serial_mem_slave_chk.sv
// Module: serial_mem_slave_chk
// Purpose: temporal properties of the serial memory slave, attached to
// the top module by the bind statement at the end of this file.
module serial_mem_slave_chk
    import serial_mem_pkg::*;
#(
    parameter int ADDR_W = 13
) (
    input logic              clk,
    input logic              rst_n,
    input logic              spi_miso_oe,
    input ctl_state_t        ctl_state,
    input logic              wr_req,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [ADDR_W-1:0] addr_cnt,
    input logic              paused,
    input logic [2:0]        bit_cnt,
    input logic              wel,
    input logic              sclk_rise
);
    // R12: the output is enabled only in a data-returning state
    a_r12_oe_in_output_state: assert property (@(posedge clk) disable iff (!rst_n)
        spi_miso_oe |-> (ctl_state == ST_RD_DATA || ctl_state == ST_STAT_OUT));

    // R7: a write request lasts exactly one cycle
    a_r7_wr_req_single: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req |=> !wr_req);

    // R8: the counter is one past the requested address, modulo the array size
    a_r8_addr_follows: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req |-> (wr_addr + ADDR_W'(1) == addr_cnt));

    // R11: the bit position does not move while paused
    a_r11_pause_freezes: assert property (@(posedge clk) disable iff (!rst_n)
        (paused && $past(paused)) |-> $stable(bit_cnt));

    // R3: the latch rises only on a received clock edge
    a_r3_wel_on_edge: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wel) |-> $past(sclk_rise));

endmodule

bind serial_mem_slave serial_mem_slave_chk #(.ADDR_W(ADDR_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .spi_miso_oe(spi_miso_oe),
    .ctl_state(ctl_state), .wr_req(wr_req), .wr_addr(wr_addr),
    .addr_cnt(addr_cnt), .paused(paused), .bit_cnt(bit_cnt),
    .wel(wel), .sclk_rise(sclk_rise)
);

// File: tb/serial_mem_slave_tb_top.sv
// Bench: drives serial frames in modes 0 and 3 and compares against a byte
// model kept in the bench.
module serial_mem_slave_tb_top;
    localparam int ADDR_W = 13;
    localparam int HALF   = 8;
    localparam int AMASK  = (1 << ADDR_W) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic spi_sclk = 1'b0, spi_csn = 1'b1, spi_mosi = 1'b0, spi_holdn = 1'b1;
    logic spi_miso, spi_miso_oe;
    logic [2:0] prot_cfg = 3'b101;
    logic stat_permit = 1'b1;
    logic stat_wr_req, wel, wr_req, wr_permit;
    logic [7:0] stat_wr_data, wr_data;
    logic [ADDR_W-1:0] wr_addr;

    logic blk_on = 1'b0;
    int   blk_lo = 'h1000;
    assign wr_permit = !(blk_on && (int'(wr_addr) >= blk_lo));

    always #10 clk = ~clk;

    serial_mem_slave #(.ADDR_W(ADDR_W)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .spi_sclk(spi_sclk), .spi_csn(spi_csn), .spi_mosi(spi_mosi), .spi_holdn(spi_holdn),
        .spi_miso(spi_miso), .spi_miso_oe(spi_miso_oe),
        .prot_cfg(prot_cfg), .stat_permit(stat_permit),
        .stat_wr_req(stat_wr_req), .stat_wr_data(stat_wr_data), .wel(wel),
        .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data), .wr_permit(wr_permit)
    );

    int n_chk = 0, n_err = 0;
    bit finished = 1'b0;
    bit mode3 = 1'b0;
    bit oe_seen = 1'b0;
    bit m_wel = 1'b0;
    logic [7:0] model [0:8191];
    int stat_cnt = 0;
    logic [7:0] stat_last = 8'h00;

    always @(posedge clk) if (rst_n && stat_wr_req) begin
        stat_cnt  <= stat_cnt + 1;
        stat_last <= stat_wr_data;
    end

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_err++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic frame_begin();
        @(negedge clk);
        spi_sclk = mode3;
        repeat (HALF) @(negedge clk);
        spi_csn = 1'b0;
        oe_seen = 1'b0;
        repeat (HALF) @(negedge clk);
    endtask

    task automatic frame_end();
        @(negedge clk);
        if (!mode3) spi_sclk = 1'b0;
        repeat (HALF) @(negedge clk);
        spi_csn = 1'b1;
        repeat (2 * HALF) @(negedge clk);
    endtask

    task automatic xfer(input logic [7:0] tx, output logic [7:0] rx, input bit do_hold);
        for (int i = 7; i >= 0; i--) begin
            @(negedge clk);
            spi_sclk = 1'b0;
            spi_mosi = tx[i];
            if (do_hold && i == 3) begin
                repeat (4) @(negedge clk);
                spi_holdn = 1'b0;
                repeat (HALF) @(negedge clk);
                for (int k = 0; k < 3; k++) begin
                    spi_sclk = 1'b1;
                    repeat (HALF) @(negedge clk);
                    spi_sclk = 1'b0;
                    repeat (HALF) @(negedge clk);
                end
                chk("R11 oe during pause", spi_miso_oe, 0);
                spi_holdn = 1'b1;
            end
            repeat (HALF) @(negedge clk);
            rx[i] = spi_miso;
            if (spi_miso_oe) oe_seen = 1'b1;
            spi_sclk = 1'b1;
            repeat (HALF - 1) @(negedge clk);
        end
    endtask

    task automatic send(input logic [7:0] tx);
        logic [7:0] rx;
        xfer(tx, rx, 1'b0);
    endtask

    task automatic cmd1(input logic [7:0] op);
        frame_begin();
        send(op);
        frame_end();
        if (op == 8'h06) m_wel = 1'b1;
        if (op == 8'h04) m_wel = 1'b0;
    endtask

    task automatic rdsr_check(input string req);
        logic [7:0] rx;
        frame_begin();
        send(8'h05);
        xfer(8'h00, rx, 1'b0);
        chk(req, rx, {prot_cfg[2], 3'b000, prot_cfg[1:0], m_wel, 1'b0});
        xfer(8'h00, rx, 1'b0);
        chk({req, " repeat"}, rx, {prot_cfg[2], 3'b000, prot_cfg[1:0], m_wel, 1'b0});
        frame_end();
    endtask

    function automatic bit allowed(input int a);
        return !(blk_on && a >= blk_lo);
    endfunction

    task automatic write_burst(input int addr, input int n, input int base, input int step);
        frame_begin();
        send(8'h02);
        send(8'hA0 | 8'((addr >> 8) & 'h1F));
        send(8'(addr & 'hFF));
        for (int i = 0; i < n; i++) begin
            int a;
            logic [7:0] d;
            a = (addr + i) & AMASK;
            d = 8'(base + i * step);
            send(d);
            if (m_wel && allowed(a)) model[a] = d;
        end
        frame_end();
        m_wel = 1'b0;
    endtask

    task automatic read_burst(input string req, input int addr, input int n,
                              input logic [7:0] fill, input bit hold_first);
        logic [7:0] rx;
        frame_begin();
        send(8'h03);
        send(8'hE0 | 8'((addr >> 8) & 'h1F));
        send(8'(addr & 'hFF));
        for (int i = 0; i < n; i++) begin
            int a;
            a = (addr + i) & AMASK;
            xfer(fill, rx, hold_first && i == 1);
            chk(req, rx, model[a]);
        end
        frame_end();
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        logic [7:0] rx;
        int sc;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        // R1: quiet outputs after reset
        chk("R1 oe", spi_miso_oe, 0);
        chk("R1 wr_req", wr_req, 0);
        chk("R1 wel", wel, 0);
        chk("R1 stat_wr_req", stat_wr_req, 0);

        // R4 and R12: status byte and output enable while returning it
        rdsr_check("R4 status after reset");
        chk("R12 oe seen on status", oe_seen, 1);
        // R3: latch set and clear
        cmd1(8'h06);
        chk("R3 wel set", wel, 1);
        rdsr_check("R3 status shows latch");
        cmd1(8'h04);
        chk("R3 wel cleared", wel, 0);
        rdsr_check("R3 status after clear");

        // R7, R6, R2: burst write then read back, garbage in top address bits
        cmd1(8'h06);
        write_burst('h0123, 16, 3, 7);
        chk("R7 wel cleared after write", wel, 0);
        read_burst("R6 read back burst", 'h0123, 16, 8'h00, 1'b0);
        cmd1(8'h06);
        write_burst('h0040, 2, 'h5A, 1);
        // R7: write with latch clear leaves memory alone
        write_burst('h0125, 2, 'hF0, 1);
        read_burst("R7 no write without latch", 'h0124, 3, 8'h00, 1'b0);

        // R8: wrap across the top of the array
        cmd1(8'h06);
        write_burst('h1FFE, 4, 'h90, 9);
        read_burst("R8 wrap read", 'h1FFE, 4, 8'h00, 1'b0);

        // R2: mode 3 read and write
        mode3 = 1'b1;
        read_burst("R2 mode3 read", 'h0120, 8, 8'h00, 1'b0);
        cmd1(8'h06);
        write_burst('h0200, 5, 'h11, 13);
        read_burst("R2 mode3 readback", 'h0200, 5, 8'h00, 1'b0);
        mode3 = 1'b0;

        // R7: permit boundary
        cmd1(8'h06);
        write_burst('h0FFE, 4, 'h20, 1);
        blk_on = 1'b1;
        cmd1(8'h06);
        write_burst('h0FFE, 4, 'hC0, 1);
        blk_on = 1'b0;
        read_burst("R7 permit boundary", 'h0FFE, 4, 8'h00, 1'b0);

        // R5: status write only with latch and permit
        sc = stat_cnt;
        cmd1(8'h06);
        frame_begin(); send(8'h01); send(8'h8C); frame_end();
        m_wel = 1'b0;
        chk("R5 status write count", stat_cnt, sc + 1);
        chk("R5 status write data", stat_last, 8'h8C);
        chk("R5 wel cleared", wel, 0);
        frame_begin(); send(8'h01); send(8'h33); frame_end();
        chk("R5 no status write without latch", stat_cnt, sc + 1);
        stat_permit = 1'b0;
        cmd1(8'h06);
        frame_begin(); send(8'h01); send(8'h44); frame_end();
        m_wel = 1'b0;
        chk("R5 no status write without permit", stat_cnt, sc + 1);
        stat_permit = 1'b1;

        // R9: bytes after a no-data command are ignored
        frame_begin(); send(8'h06); send(8'h02); send(8'h00); send(8'h40); send(8'hAA); frame_end();
        m_wel = 1'b1;
        chk("R9 latch from first byte", wel, 1);
        read_burst("R9 second command ignored", 'h0040, 1, 8'h00, 1'b0);

        // R10: unknown command discards the frame
        frame_begin(); send(8'h55); send(8'h02); send(8'h00); send(8'h40); send(8'h77); frame_end();
        chk("R10 no output on unknown", oe_seen, 0);
        read_burst("R10 memory unchanged", 'h0040, 2, 8'h00, 1'b0);
        cmd1(8'h04);

        // R11: pause inside a read byte
        read_burst("R11 read across pause", 'h0123, 4, 8'h00, 1'b1);
        // R6: data-in ignored during read
        read_burst("R6 read with active data-in", 'h0123, 6, 8'hA5, 1'b0);
        read_burst("R6 memory intact", 'h0123, 6, 8'h00, 1'b0);
        // R12: write frame never enables output
        cmd1(8'h06);
        write_burst('h0300, 2, 'h01, 1);
        chk("R12 no output on write", oe_seen, 0);

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
        $finish;
    end

endmodule